// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block holds the interrupt status of a descriptor-driven DMA engine in an SD/MMC host controller. It gathers single-cycle event pulses from the DMA and card logic: transfer-complete events for each direction, a descriptor that the DMA does not own, host bus aborts, and a set of card error flags. Each cause is latched into a sticky status bit that software clears by writing a 1 to it.

Two summary bits sit above the cause bits. The normal summary covers completed transfers and the abnormal summary covers faults. Each summary counts only causes whose enable bit is set, and each is itself sticky. One registered interrupt line is driven from the two summaries. A bus abort latches a fatal flag and a 3-bit code that records the direction of the abort. While the fatal flag is set, a halt output tells the DMA to stop all bus accesses.

Software reaches the block through a simple word-addressed port. Status is at word 0 and the enable mask is at word 1. Reads return data one cycle after the request.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, the status word and the mask word both read 0, and `irq` and `dma_halt` are both low.
- R2: A pulse on `tx_done` sets status bit 0 and a pulse on `rx_done` sets status bit 1, one cycle after the pulse. A set bit stays set until software clears it.
- R3: A pulse on any one of the seven `card_err` flags sets the card error summary at status bit 5.
- R4: When `desc_fetch_done` pulses with `desc_own` at 0, status bit 4 (descriptor unavailable) sets. When `desc_own` is 1, the pulse has no effect.
- R5: A pulse on `abort_tx` or `abort_rx` sets the fatal flag at status bit 2. `dma_halt` is high from the next cycle and stays high until bit 2 is cleared.
- R6: The error code at status bits 12:10 loads when the fatal flag sets: 3'b001 for a transmit abort, 3'b010 for a receive abort, with transmit winning when both pulse together. While the flag stays set, the code holds against later aborts. It ignores writes and returns to 0 when bit 2 clears.
- R7: The normal summary (bit 8) sets one cycle after bit 0 or bit 1 is set with its enable bit on. Causes whose enable bit is off never set it.
- R8: The abnormal summary (bit 9) sets one cycle after bit 2, 4 or 5 is set with its enable bit on. This includes the case where the enable is turned on after the cause is already set.
- R9: A status write clears each of bits 0, 1, 2, 4, 5, 8 and 9 where the written data has a 1, and leaves bits written 0 alone. A summary whose enabled cause is cleared in the same write stays set and needs a second clear. Reserved bits 3, 6, 7 and 31:13 read 0.
- R10: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R11: `irq` is the OR of the two summary bits, delayed by one register stage.
- R12: The mask word keeps only bits 0, 1, 2, 4 and 5; all other bits read 0. `rd_data` updates one cycle after `rd_en` and holds while `rd_en` is low. Addresses other than 0 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 1 | Transmit transfer complete pulse |
| rx_done | input | 1 | Receive transfer complete pulse |
| desc_fetch_done | input | 1 | Descriptor fetched pulse |
| desc_own | input | 1 | Ownership flag of the fetched descriptor (1 = owned by DMA) |
| abort_tx | input | 1 | Host bus abort during transmit, pulse |
| abort_rx | input | 1 | Host bus abort during receive, pulse |
| card_err | input | N_CARD_ERR | Card error flag pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Registered interrupt, active high |
| dma_halt | output | 1 | Stop DMA bus accesses |

## Verification
The results follow a fixed pipeline. A cause bit and `dma_halt` change one edge after the event pulse, a summary bit one edge after its cause bit, and `irq` one edge after the summary, so the delay from pulse to interrupt is three edges. A write acts on the edge that samples it, and read data appears one edge after `rd_en`. The bench drives inputs and samples outputs on falling edges and counts rising edges explicitly between them. Every check therefore lands in the exact cycle where the value is due, including the cycle just before a summary or `irq` rises.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  // number of latched causes and how many belong to the normal tier
  localparam int N_CAUSE = 5;
  localparam int N_NOR   = 2;

  // bit positions in the status and mask words
  localparam int BIT_NOR = 8;
  localparam int BIT_ABN = 9;
  localparam int BIT_ET  = 10;
  localparam int ET_W    = 3;

  // cause index order: tx, rx, fatal, desc unavailable, card error
  localparam int C_TX    = 0;
  localparam int C_RX    = 1;
  localparam int C_FATAL = 2;
  localparam int C_DU    = 3;
  localparam int C_CE    = 4;

  localparam logic [ET_W-1:0] ET_NONE = 3'b000;
  localparam logic [ET_W-1:0] ET_TX   = 3'b001;
  localparam logic [ET_W-1:0] ET_RX   = 3'b010;

  // word position of each cause index
  function automatic int cause_bit(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      3:       return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/dis_sticky_bit.sv
module dis_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
endmodule

// File: rtl/dis_err_code.sv
module dis_err_code
  import dma_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            abort_tx,
  input  logic            abort_rx,
  input  logic            fatal_q,
  input  logic            fatal_clr,
  output logic [ET_W-1:0] code
);
  logic any_abort;
  assign any_abort = abort_tx | abort_rx;

  always_ff @(posedge clk) begin
    if (rst)
      code <= ET_NONE;
    else if (!fatal_q && any_abort)
      code <= abort_tx ? ET_TX : ET_RX;
    else if (fatal_clr && !any_abort)
      code <= ET_NONE;
  end

  assert_code_zero_without_fatal_R6: assert property (@(posedge clk) disable iff (rst)
    !fatal_q |-> (code == ET_NONE));
  assert_code_legal_with_fatal_R6: assert property (@(posedge clk) disable iff (rst)
    fatal_q |-> (code == ET_TX || code == ET_RX));
endmodule

// File: rtl/dis_summary.sv
module dis_summary
  import dma_irq_pkg::*;
#(
  parameter int NC = N_CAUSE,
  parameter int NN = N_NOR
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] cause_q,
  input  logic [NC-1:0] mask_q,
  input  logic          nor_clr,
  input  logic          abn_clr,
  output logic          nor_q,
  output logic          abn_q,
  output logic          irq_q
);
  logic [NC-1:0] live;
  logic          nor_set;
  logic          abn_set;

  assign live    = cause_q & mask_q;
  assign nor_set = |live[NN-1:0];
  assign abn_set = |live[NC-1:NN];

  dis_sticky_bit u_nor (
    .clk (clk), .rst (rst), .set (nor_set), .clr (nor_clr), .q (nor_q)
  );

  dis_sticky_bit u_abn (
    .clk (clk), .rst (rst), .set (abn_set), .clr (abn_clr), .q (abn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= nor_q | abn_q;
  end

  assert_nor_needs_enabled_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(nor_q) |-> $past(|(cause_q[NN-1:0] & mask_q[NN-1:0])));
  assert_abn_needs_enabled_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(abn_q) |-> $past(|(cause_q[NC-1:NN] & mask_q[NC-1:NN])));
  assert_irq_rises_after_summary_R11: assert property (@(posedge clk) disable iff (rst)
    (nor_q || abn_q) |=> irq_q);
  assert_irq_low_without_summary_R11: assert property (@(posedge clk) disable iff (rst)
    !(nor_q || abn_q) |=> !irq_q);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 2,
  parameter int N_CARD_ERR = 7,
  parameter int STAT_ADDR  = 0,
  parameter int MASK_ADDR  = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tx_done,
  input  logic                  rx_done,
  input  logic                  desc_fetch_done,
  input  logic                  desc_own,
  input  logic                  abort_tx,
  input  logic                  abort_rx,
  input  logic [N_CARD_ERR-1:0] card_err,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  irq,
  output logic                  dma_halt
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

  logic                wr_stat;
  logic                wr_mask;
  logic [N_CAUSE-1:0]  cause_set;
  logic [N_CAUSE-1:0]  cause_clr;
  logic [N_CAUSE-1:0]  cause_q;
  logic [N_CAUSE-1:0]  mask_q;
  logic                nor_q;
  logic                abn_q;
  logic [ET_W-1:0]     err_code;
  logic [DATA_W-1:0]   stat_word;
  logic [DATA_W-1:0]   mask_word;
  logic                unused_wr_bits;

  assign wr_stat = wr_en && (wr_addr == STAT_A);
  assign wr_mask = wr_en && (wr_addr == MASK_A);
  assign unused_wr_bits = ^wr_data;

  // event decode into cause set requests
  assign cause_set[C_TX]    = tx_done;
  assign cause_set[C_RX]    = rx_done;
  assign cause_set[C_FATAL] = abort_tx | abort_rx;
  assign cause_set[C_DU]    = desc_fetch_done & ~desc_own;
  assign cause_set[C_CE]    = |card_err;

  for (genvar g = 0; g < N_CAUSE; g++) begin : g_cause
    assign cause_clr[g] = wr_stat & wr_data[cause_bit(g)];

    dis_sticky_bit u_bit (
      .clk (clk), .rst (rst), .set (cause_set[g]), .clr (cause_clr[g]), .q (cause_q[g])
    );

    always_ff @(posedge clk) begin
      if (rst)          mask_q[g] <= 1'b0;
      else if (wr_mask) mask_q[g] <= wr_data[cause_bit(g)];
    end
  end

  dis_err_code u_code (
    .clk       (clk),
    .rst       (rst),
    .abort_tx  (abort_tx),
    .abort_rx  (abort_rx),
    .fatal_q   (cause_q[C_FATAL]),
    .fatal_clr (cause_clr[C_FATAL]),
    .code      (err_code)
  );

  dis_summary #(.NC(N_CAUSE), .NN(N_NOR)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .nor_clr (wr_stat & wr_data[BIT_NOR]),
    .abn_clr (wr_stat & wr_data[BIT_ABN]),
    .nor_q   (nor_q),
    .abn_q   (abn_q),
    .irq_q   (irq)
  );

  assign dma_halt = cause_q[C_FATAL];

  always_comb begin
    stat_word = '0;
    mask_word = '0;
    for (int i = 0; i < N_CAUSE; i++) begin
      stat_word[cause_bit(i)] = cause_q[i];
      mask_word[cause_bit(i)] = mask_q[i];
    end
    stat_word[BIT_NOR] = nor_q;
    stat_word[BIT_ABN] = abn_q;
    stat_word[BIT_ET +: ET_W] = err_code;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= (rd_addr == STAT_A) ? stat_word :
                 (rd_addr == MASK_A) ? mask_word : '0;
  end

  assert_halt_after_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (abort_tx || abort_rx) |=> dma_halt);
  assert_halt_carries_code_R6: assert property (@(posedge clk) disable iff (rst)
    dma_halt |-> (err_code != ET_NONE));
  assert_reserved_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data[3] == 1'b0) && (rd_data[7:6] == 2'b00) && (rd_data[DATA_W-1:BIT_ET+ET_W] == '0));
  assert_du_sets_when_unowned_R4: assert property (@(posedge clk) disable iff (rst)
    (desc_fetch_done && !desc_own) |=> cause_q[C_DU]);
endmodule

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int NCE = 7;

  logic           clk = 1'b0;
  logic           rst;
  logic           tx_done, rx_done, desc_fetch_done, desc_own, abort_tx, abort_rx;
  logic [NCE-1:0] card_err;
  logic           wr_en, rd_en;
  logic [AW-1:0]  wr_addr, rd_addr;
  logic [DW-1:0]  wr_data;
  logic [DW-1:0]  rd_data;
  logic           irq, dma_halt;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status dut_i (
    .clk (clk), .rst (rst),
    .tx_done (tx_done), .rx_done (rx_done),
    .desc_fetch_done (desc_fetch_done), .desc_own (desc_own),
    .abort_tx (abort_tx), .abort_rx (abort_rx), .card_err (card_err),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
    .irq (irq), .dma_halt (dma_halt)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic read_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    tick();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic clear_all();
    write_reg(2'd0, 32'h0000_0337);
    write_reg(2'd0, 32'h0000_0337);
    tick();
  endtask

  task automatic test_reset();
    logic [DW-1:0] d;
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 halt", {31'b0, dma_halt}, 32'h0);
    read_reg(2'd0, d); check("R1 status", d, 32'h0);
    read_reg(2'd1, d); check("R1 mask", d, 32'h0);
  endtask

  task automatic test_tx_sticky();
    logic [DW-1:0] d;
    write_reg(2'd1, 32'h0);
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    repeat (3) tick();
    read_reg(2'd0, d); check("R2 tx sticky, R7 masked no summary", d, 32'h001);
    check("R7 masked irq low", {31'b0, irq}, 32'h0);
    write_reg(2'd0, 32'h0);
    read_reg(2'd0, d); check("R9 zero write keeps bit", d, 32'h001);
    write_reg(2'd0, 32'h1);
    read_reg(2'd0, d); check("R9 clear tx", d, 32'h0);
  endtask

  task automatic test_normal_summary();
    logic [DW-1:0] d;
    write_reg(2'd1, 32'h3);
    rx_done = 1'b1; tick(); rx_done = 1'b0;
    check("R11 irq low after cause edge", {31'b0, irq}, 32'h0);
    tick();
    check("R11 irq low at summary edge", {31'b0, irq}, 32'h0);
    tick();
    check("R11 irq high", {31'b0, irq}, 32'h1);
    read_reg(2'd0, d); check("R2 R7 rx and normal summary", d, 32'h102);
    write_reg(2'd0, 32'h102);
    read_reg(2'd0, d); check("R9 summary needs second clear", d, 32'h100);
    write_reg(2'd0, 32'h100);
    check("R11 irq lags summary clear", {31'b0, irq}, 32'h1);
    tick();
    check("R11 irq low", {31'b0, irq}, 32'h0);
    read_reg(2'd0, d); check("R9 all clear", d, 32'h0);
  endtask

  task automatic test_card_err();
    logic [DW-1:0] d;
    write_reg(2'd1, 32'h0);
    for (int i = 0; i < NCE; i++) begin
      card_err = '0; card_err[i] = 1'b1; tick(); card_err = '0;
      read_reg(2'd0, d); check($sformatf("R3 card flag %0d", i), d, 32'h020);
      write_reg(2'd0, 32'h020);
      read_reg(2'd0, d); check("R3 card clear", d, 32'h0);
    end
  endtask

  task automatic test_desc();
    logic [DW-1:0] d;
    desc_own = 1'b1; desc_fetch_done = 1'b1; tick(); desc_fetch_done = 1'b0;
    read_reg(2'd0, d); check("R4 owned descriptor ignored", d, 32'h0);
    desc_own = 1'b0; desc_fetch_done = 1'b1; tick(); desc_fetch_done = 1'b0;
    read_reg(2'd0, d); check("R4 unowned descriptor", d, 32'h010);
    write_reg(2'd0, 32'h010);
  endtask

  task automatic test_fatal();
    logic [DW-1:0] d;
    abort_tx = 1'b1; tick(); abort_tx = 1'b0;
    check("R5 halt raised", {31'b0, dma_halt}, 32'h1);
    read_reg(2'd0, d); check("R6 tx code", d, 32'h404);
    abort_rx = 1'b1; tick(); abort_rx = 1'b0;
    read_reg(2'd0, d); check("R6 code holds", d, 32'h404);
    write_reg(2'd0, 32'h1C00);
    read_reg(2'd0, d); check("R6 code ignores write", d, 32'h404);
    check("R5 halt held", {31'b0, dma_halt}, 32'h1);
    write_reg(2'd0, 32'h004);
    check("R5 halt released", {31'b0, dma_halt}, 32'h0);
    read_reg(2'd0, d); check("R6 code cleared with flag", d, 32'h0);
    abort_rx = 1'b1; tick(); abort_rx = 1'b0;
    read_reg(2'd0, d); check("R6 rx code", d, 32'h804);
    write_reg(2'd0, 32'h004);
    abort_tx = 1'b1; abort_rx = 1'b1; tick(); abort_tx = 1'b0; abort_rx = 1'b0;
    read_reg(2'd0, d); check("R6 tx wins", d, 32'h404);
    write_reg(2'd0, 32'h004);
    check("R8 masked fatal irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic test_set_wins();
    logic [DW-1:0] d;
    tx_done = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1;
    tick();
    tx_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    read_reg(2'd0, d); check("R10 set beats clear", d, 32'h001);
    write_reg(2'd0, 32'h1);
  endtask

  task automatic test_mask_port();
    logic [DW-1:0] d;
    write_reg(2'd1, 32'hFFFF_FFFF);
    read_reg(2'd1, d); check("R12 mask bits", d, 32'h37);
    tick();
    check("R12 read data holds", rd_data, 32'h37);
    read_reg(2'd2, d); check("R12 unmapped reads zero", d, 32'h0);
    write_reg(2'd1, 32'h0);
  endtask

  task automatic test_late_enable();
    logic [DW-1:0] d;
    desc_own = 1'b0; desc_fetch_done = 1'b1; tick(); desc_fetch_done = 1'b0;
    repeat (2) tick();
    read_reg(2'd0, d); check("R8 masked no summary", d, 32'h010);
    write_reg(2'd1, 32'h10);
    tick(); tick();
    check("R8 irq after late enable", {31'b0, irq}, 32'h1);
    read_reg(2'd0, d); check("R8 abnormal summary", d, 32'h210);
    clear_all();
    write_reg(2'd1, 32'h0);
  endtask

  task automatic test_all_causes();
    logic [DW-1:0] d;
    write_reg(2'd1, 32'h37);
    tx_done = 1'b1; rx_done = 1'b1; abort_tx = 1'b1;
    desc_own = 1'b0; desc_fetch_done = 1'b1; card_err = 7'h01;
    tick();
    tx_done = 1'b0; rx_done = 1'b0; abort_tx = 1'b0; desc_fetch_done = 1'b0; card_err = '0;
    repeat (2) tick();
    read_reg(2'd0, d); check("R9 reserved bits zero", d, 32'h737);
    check("R11 irq on both tiers", {31'b0, irq}, 32'h1);
    clear_all();
    read_reg(2'd0, d); check("R9 full clear", d, 32'h0);
    check("R11 irq cleared", {31'b0, irq}, 32'h0);
    check("R5 halt cleared", {31'b0, dma_halt}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1;
    tx_done = 0; rx_done = 0; desc_fetch_done = 0; desc_own = 1;
    abort_tx = 0; abort_rx = 0; card_err = '0;
    wr_en = 0; wr_addr = '0; wr_data = '0; rd_en = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_tx_sticky();
    test_normal_summary();
    test_card_err();
    test_desc();
    test_fatal();
    test_set_wins();
    test_mask_port();
    test_late_enable();
    test_all_causes();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule